// File: doc/BRIEF.md
# Two-Wire Serial Wiper-Code Slave

This block is the serial front end of a 128-step digitally controlled resistor. It sits on a two-wire serial bus (clock and open-drain data) as a slave with one fixed 7-bit address. It holds one 7-bit wiper code that selects the tap position of the resistor array. A master sets the code with a two-byte write: the address with a write flag, then one data byte. A master reads the code back with a one-byte read.

Both bus lines are sampled on a faster system clock through two-stage synchronizers. Start and stop conditions and clock edges are found from the synchronized samples. The block never drives a line high. It only asserts an enable that pulls the data line low. There is no register pointer. The byte after the address goes straight into the wiper code, and a read returns the wiper code directly.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After the active-low reset `rstN`, the wiper code is 64 (mid-scale) and the data-line pull-down is off.
- R2: A falling data line while the clock line is high (start) begins address reception from any state. A rising data line while the clock line is high (stop) returns the slave to idle without changing the wiper code, and the pull-down is off on the next cycle.
- R3: The first byte after a start is received MSB first as a 7-bit address followed by a direction bit (0 = write, 1 = read). When the address is 0101110, the slave pulls the data line low from the clock fall after the eighth bit until the clock fall that ends the ninth pulse. The pull-down changes only on clock falls and stays constant while the clock line is high.
- R4: For any other address, the slave leaves the data line released for the whole transfer and leaves the wiper code unchanged.
- R5: In a write, bits 6..0 of the byte after the acknowledged address become the wiper code on the clock fall after its eighth bit. Bit 7 of that byte is ignored. The wiper code changes at no other time.
- R6: The slave acknowledges that data byte in its ninth clock slot. Any further byte in the same transfer is neither acknowledged nor stored.
- R7: In a read, the slave drives a 0 and then wiper bits 6..0, MSB first. Each bit is valid from the clock fall before its pulse. The data line is released in the ninth slot, where the master gives its no-acknowledge, and the slave then goes idle.
- R8: A start that arrives partway through a byte discards the partial byte, leaves the wiper code unchanged, and begins a new address phase.
- R9: A change of the pull-down or the wiper code caused by a bus event appears within 4 system clocks of that bus event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sdaDrvLow | output | 1 | 1 = pull the data line low; 0 = release it |
| wiperCode | output | 7 | Current wiper position, 0 to 127 |

## Verification
The clock fall that ends the eighth data bit of a write does two things on the same system clock: the datapath loads the new wiper code, and the controller raises the acknowledge pull-down. The bench reaches this case in every accepted write. A behavioural model updates its expected wiper code and its expected pull-down at that same bus edge. Both outputs are then compared on every system clock once the synchronizer latency has passed, so a design that splits the two actions across different edges, or drops either one, shows up as a mismatch.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } ctrlState_t;

  // Strobes and levels from the control FSM to the datapath
  typedef struct packed {
    logic shiftRx;    // sample one received bit
    logic loadWiper;  // commit received byte into wiper code
    logic loadTx;     // load transmit frame from wiper code
    logic shiftTx;    // advance transmit frame by one bit
    logic driveAck;   // hold data line low for acknowledge
    logic driveTx;    // transmit frame MSB owns the data line
  } ctrlStrobe_t;

endpackage

// File: rtl/wiper_i2c_sync.sv
module wiper_i2c_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclQ,
  output logic sdaQ,
  output logic startDet,
  output logic stopDet,
  output logic sclRise,
  output logic sclFall
);

  logic [Stages:0] sclPipe;
  logic [Stages:0] sdaPipe;

  assign sclPipe[0] = sclIn;
  assign sdaPipe[0] = sdaIn;

  for (genvar i = 1; i <= Stages; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclPipe[i] <= 1'b1;
        sdaPipe[i] <= 1'b1;
      end else begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
    end
  end

  assign sclS = sclPipe[Stages];
  assign sdaS = sdaPipe[Stages];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;

endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl
  import wiper_i2c_pkg::*;
#(
  parameter int ByteW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        addrMatch,
  input  logic        rwBit,
  output ctrlStrobe_t strobe
);

  localparam int CntW = $clog2(ByteW + 1);
  localparam logic [CntW-1:0] FullCnt = CntW'(ByteW);
  localparam logic [CntW-1:0] LastTx  = CntW'(ByteW - 1);

  ctrlState_t state;
  logic [CntW-1:0] bitCnt;
  logic busEvent;

  assign busEvent = startDet | stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == FullCnt) begin
            state  <= addrMatch ? ST_ADDR_ACK : ST_IDLE;
            bitCnt <= '0;
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            state  <= rwBit ? ST_RD : ST_WR;
            bitCnt <= '0;
          end
        end
        ST_WR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == FullCnt) begin
            state  <= ST_WR_ACK;
            bitCnt <= '0;
          end
        end
        ST_WR_ACK: if (sclFall) state <= ST_IDLE;
        ST_RD: begin
          if (sclFall) begin
            if (bitCnt == LastTx) begin
              state  <= ST_RD_ACK;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: if (sclFall) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.shiftRx   = sclRise & ~busEvent & (state == ST_ADDR || state == ST_WR);
    strobe.loadWiper = sclFall & ~busEvent & (state == ST_WR) & (bitCnt == FullCnt);
    strobe.loadTx    = sclFall & ~busEvent & (state == ST_ADDR_ACK) & rwBit;
    strobe.shiftTx   = sclFall & ~busEvent & (state == ST_RD);
    strobe.driveAck  = (state == ST_ADDR_ACK) || (state == ST_WR_ACK);
    strobe.driveTx   = (state == ST_RD);
  end

endmodule

// File: rtl/wiper_i2c_datapath.sv
module wiper_i2c_datapath
  import wiper_i2c_pkg::*;
#(
  parameter int               WiperW    = 7,
  parameter logic [WiperW-1:0] SlaveAddr = 7'b0101110,
  parameter logic [WiperW-1:0] ResetCode = 7'd64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  ctrlStrobe_t       strobe,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              sdaDrvLow,
  output logic [WiperW-1:0] wiperCode
);

  localparam int ByteW = WiperW + 1;

  logic [ByteW-1:0] rxShift;
  logic [ByteW-1:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strobe.shiftRx) rxShift <= {rxShift[ByteW-2:0], sdaS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wiperCode <= ResetCode;
    else if (strobe.loadWiper) wiperCode <= rxShift[WiperW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '1;
    else if (strobe.loadTx) txShift <= {1'b0, wiperCode};
    else if (strobe.shiftTx) txShift <= {txShift[ByteW-2:0], 1'b1};
  end

  assign addrMatch = (rxShift[ByteW-1:1] == SlaveAddr);
  assign rwBit     = rxShift[0];
  assign sdaDrvLow = strobe.driveAck | (strobe.driveTx & ~txShift[ByteW-1]);

endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wiper_i2c_pkg::*;
#(
  parameter int               WiperW     = 7,
  parameter logic [WiperW-1:0] SlaveAddr  = 7'b0101110,
  parameter int               SyncStages = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDrvLow,
  output logic [WiperW-1:0] wiperCode
);

  localparam int ByteW = WiperW + 1;
  localparam logic [WiperW-1:0] MidCode = WiperW'(1 << (WiperW - 1));

  logic sclS, sdaS, sclQ, sdaQ;
  logic startDet, stopDet, sclRise, sclFall;
  logic addrMatch, rwBit;
  ctrlStrobe_t strobe;

  wiper_i2c_sync #(.Stages(SyncStages)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclQ(sclQ), .sdaQ(sdaQ),
    .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall)
  );

  wiper_i2c_ctrl #(.ByteW(ByteW)) uCtrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall),
    .addrMatch(addrMatch), .rwBit(rwBit), .strobe(strobe)
  );

  wiper_i2c_datapath #(
    .WiperW(WiperW), .SlaveAddr(SlaveAddr), .ResetCode(MidCode)
  ) uData (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .strobe(strobe),
    .addrMatch(addrMatch), .rwBit(rwBit),
    .sdaDrvLow(sdaDrvLow), .wiperCode(wiperCode)
  );

endmodule

// File: rtl/wiper_i2c_checker.sv
module wiper_i2c_checker #(
  parameter int WiperW = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclS,
  input logic              sclQ,
  input logic              sdaS,
  input logic              sdaQ,
  input logic              sdaDrvLow,
  input logic [WiperW-1:0] wiperCode
);

  localparam logic [WiperW-1:0] MidCode = WiperW'(1 << (WiperW - 1));

  // R1: reset forces mid-scale
  a_r1_reset_midscale: assert property (@(posedge clk)
    !rstN |=> wiperCode == MidCode);

  // R2: a stop condition releases the data line
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclQ && sdaS && !sdaQ) |=> !sdaDrvLow);

  // R3: pull-down constant while the clock line is high
  a_r3_drive_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclQ) |-> $stable(sdaDrvLow));

  // R5: wiper code moves only right after a clock fall
  a_r5_wiper_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wiperCode) |-> $past(sclQ && !sclS));

  // R9: pull-down moves only right after a clock fall
  a_r9_drive_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> $past(sclQ && !sclS));

endmodule

bind wiper_i2c_slave wiper_i2c_checker #(.WiperW(WiperW)) uChk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sclQ(sclQ), .sdaS(sdaS),
  .sdaQ(sdaQ), .sdaDrvLow(sdaDrvLow), .wiperCode(wiperCode)
);

// File: tb/sim_wiper_i2c_slave.sv
`timescale 1ns/1ps
module sim_wiper_i2c_slave;

  localparam int P = 10;           // system clocks per bus phase
  localparam int Settle = 5;       // negedges skipped after a bus event
  localparam logic [6:0] Addr = 7'b0101110;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDrvLow;
  logic [6:0] wiperCode;
  wire  sdaLine = sdaM & ~sdaDrvLow;

  int errors = 0;
  int checks = 0;
  int settle = 0;
  bit mon = 1'b0;
  bit done = 1'b0;
  logic expDrv = 1'b0;
  logic [6:0] expWiper = 7'd64;

  always #4 clk = ~clk;

  wiper_i2c_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .wiperCode(wiperCode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (mon) begin
      if (settle > 0) settle--;
      else begin
        check(sdaDrvLow === expDrv, "R3 R9 pull-down", int'(sdaDrvLow), int'(expDrv));
        check(wiperCode === expWiper, "R5 R9 wiper code", int'(wiperCode), int'(expWiper));
      end
    end
  end

  task automatic phase();
    repeat (P) @(posedge clk);
    #1;
  endtask

  task automatic mark(input logic nextDrv, input int newW);
    expDrv = nextDrv;
    if (newW >= 0) expWiper = newW[6:0];
    settle = Settle;
  endtask

  task automatic clockBit(input logic b, input logic nextDrv, input int newW, output logic seen);
    sdaM = b;
    phase();
    sclM = 1'b1;
    phase();
    seen = sdaLine;
    sclM = 1'b0;
    mark(nextDrv, newW);
    phase();
  endtask

  task automatic startCond();
    sdaM = 1'b1;
    phase();
    sclM = 1'b1;
    phase();
    sdaM = 1'b0;
    mark(1'b0, -1);
    phase();
    sclM = 1'b0;
    phase();
  endtask

  task automatic stopCond();
    sdaM = 1'b0;
    phase();
    sclM = 1'b1;
    phase();
    sdaM = 1'b1;
    mark(1'b0, -1);
    phase();
  endtask

  task automatic sendByte(input logic [7:0] v, input logic lastDrv, input int newW);
    logic s;
    for (int i = 7; i >= 0; i--)
      clockBit(v[i], (i == 0) ? lastDrv : 1'b0, (i == 0) ? newW : -1, s);
  endtask

  task automatic ackSlot(input logic expectAck, input logic nextDrv, input string req);
    logic s;
    clockBit(1'b1, nextDrv, -1, s);
    check(s == !expectAck, req, int'(s), int'(!expectAck));
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [7:0] data, input bit extra);
    bit ok = (a == Addr);
    startCond();
    sendByte({a, 1'b0}, ok, -1);
    ackSlot(ok, 1'b0, ok ? "R3 address ack" : "R4 no address ack");
    sendByte(data, ok, ok ? int'(data[6:0]) : -1);
    ackSlot(ok, 1'b0, ok ? "R6 data ack" : "R4 data ignored");
    if (extra) begin
      sendByte(8'h11, 1'b0, -1);
      ackSlot(1'b0, 1'b0, "R6 extra byte not acknowledged");
    end
    stopCond();
    check(wiperCode == expWiper, "R5 wiper after write", int'(wiperCode), int'(expWiper));
  endtask

  task automatic doRead();
    logic [7:0] expB;
    logic [7:0] got;
    logic s;
    expB = {1'b0, expWiper};
    startCond();
    sendByte({Addr, 1'b1}, 1'b1, -1);
    ackSlot(1'b1, ~expB[7], "R3 read address ack");
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, (i > 0) ? ~expB[i-1] : 1'b0, -1, s);
      got[i] = s;
    end
    check(got == expB, "R7 read data", int'(got), int'(expB));
    clockBit(1'b1, 1'b0, -1, s);
    check(s == 1'b1, "R7 ninth slot released", int'(s), 1);
    stopCond();
  endtask

  initial begin
    logic s;
    repeat (10) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    check(wiperCode == 7'd64, "R1 reset wiper", int'(wiperCode), 64);
    check(sdaDrvLow == 1'b0, "R1 reset pull-down", int'(sdaDrvLow), 0);
    @(posedge clk);
    #1;
    mon = 1'b1;
    phase();

    doWrite(Addr, 8'h25, 1'b0);
    doRead();
    doWrite(Addr, 8'hFF, 1'b0);        // R5: bit 7 dropped -> 127
    doRead();
    doWrite(Addr, 8'h00, 1'b0);
    doRead();
    doWrite(7'b0101111, 8'h55, 1'b0);  // R4: wrong address
    doWrite(7'b1101110, 8'h2A, 1'b0);  // R4: MSB differs
    doWrite(Addr, 8'h4A, 1'b1);        // R6: trailing byte ignored
    doRead();

    // R8: restart in the middle of a data byte
    startCond();
    sendByte({Addr, 1'b0}, 1'b1, -1);
    ackSlot(1'b1, 1'b0, "R8 first address ack");
    clockBit(1'b1, 1'b0, -1, s);
    clockBit(1'b0, 1'b0, -1, s);
    clockBit(1'b1, 1'b0, -1, s);
    clockBit(1'b1, 1'b0, -1, s);
    check(wiperCode == 7'h4A, "R8 partial byte not stored", int'(wiperCode), 'h4A);
    startCond();
    sendByte({Addr, 1'b0}, 1'b1, -1);
    ackSlot(1'b1, 1'b0, "R8 restarted address ack");
    sendByte(8'h33, 1'b1, 'h33);
    ackSlot(1'b1, 1'b0, "R8 restarted data ack");
    stopCond();
    check(wiperCode == 7'h33, "R8 wiper after restart", int'(wiperCode), 'h33);

    // R2: stop in the middle of a data byte
    startCond();
    sendByte({Addr, 1'b0}, 1'b1, -1);
    ackSlot(1'b1, 1'b0, "R2 address ack");
    clockBit(1'b0, 1'b0, -1, s);
    clockBit(1'b1, 1'b0, -1, s);
    clockBit(1'b1, 1'b0, -1, s);
    stopCond();
    check(wiperCode == 7'h33, "R2 stop keeps wiper", int'(wiperCode), 'h33);
    check(sdaDrvLow == 1'b0, "R2 stop releases line", int'(sdaDrvLow), 0);
    doRead();
    doWrite(Addr, 8'h7F, 1'b0);
    doRead();

    phase();
    mon = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule